// File: doc/BRIEF.md
# Block Address Translation Matcher

This block compares a 32-bit effective address against a small set of programmable block mappings and returns, in the same cycle, a physical address, the access rights and a three-way status: miss, grant or violation. It holds two independent mapping arrays, one used only by instruction fetches and one used only by data loads and stores. A processor pipeline consults it ahead of any page-based translation. A grant means the access is already translated. A miss means the caller falls back to its slower path. A violation means a mapping covered the address but refused the access.

Each mapping is a pair of 32-bit words. The tag word carries the effective block base, a block-length mask and two enable bits, one for supervisor state and one for user state. The target word carries the physical block base and a 2-bit rights code. Software loads either word of any entry through a one-word write port. A new value is used from the cycle after the write edge.

The block has no sequencing state. The lookup is pure logic over the stored words, and only the mapping storage is clocked. Status encoding: 2'b00 miss, 2'b01 grant, 2'b10 violation.

Top module: `bat_xlate_matcher`

## Requirements
- R1: After reset every entry of both arrays is disabled, so every request misses. On a miss `rsp_status`=00, and `rsp_paddr`, `rsp_prot` and `rsp_entry` are all zero.
- R2: A request with `req_fetch`=1 consults only the instruction array. Any other request consults only the data array.
- R3: An entry takes part only if tag bit 1 (supervisor enable) is set while `req_user`=0, or tag bit 0 (user enable) is set while `req_user`=1.
- R4: Address bits [31:28] must equal tag bits [31:28]. Address bits [27:17] must equal tag bits [27:17] only where the length mask, tag bits [12:2], holds a zero. A one in mask bit k excludes address bit 17+k from the compare.
- R5: On a grant or violation, the physical address is the OR of four parts: target bits [31:28]; address bits [27:17] ANDed with the length mask; target bits [27:17]; and address bits [16:12] passed through unchanged. Bits [11:0] are zero.
- R6: Entries are searched from index 0 upward, and the lowest-indexed matching entry alone decides the result, even when it refuses the access. Its index appears on `rsp_entry`.
- R7: Target bits [1:0] code the rights: 00 gives no access, 01 and 11 give read-only, and 10 gives read/write. `rsp_prot` reports bit 0 as read allowed and bit 1 as write allowed. A fetch or a load needs read. A data store needs write. A store flag on a fetch is ignored. A failed check gives status 10. A passed check gives status 01.
- R8: With `cfg_we`=1, the word at `cfg_idx` is written on the clock edge. The array is selected by `cfg_instr` (1 = instruction) and the word by `cfg_lower` (0 = tag, 1 = target). A request in the same cycle still sees the old value, and the next cycle sees the new one.
- R9: Results depend only on the current request and the stored words, with no latency. With `req_valid`=0 the result is a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mapping storage |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for one mapping word |
| cfg_instr | input | 1 | 1 selects the instruction array, 0 the data array |
| cfg_idx | input | IDX_W (2) | Entry index to write |
| cfg_lower | input | 1 | 0 writes the tag word, 1 writes the target word |
| cfg_wdata | input | 32 | Word to store |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Effective address |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_store | input | 1 | Data request is a store |
| req_user | input | 1 | Requester is in user state |
| rsp_status | output | 2 | 00 miss, 01 grant, 10 violation |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_prot | output | 2 | Bit 0 read allowed, bit 1 write allowed |
| rsp_entry | output | IDX_W (2) | Index of the deciding entry |

## Verification
The assertions assume that the request inputs are stable between clock edges. They also assume that `rst_n` is held low until the first edge, so that the storage starts from known disabled entries. The storage checks assume that `cfg_idx` never exceeds the entry count. The stimulus changes requests and configuration only on falling edges and writes only indices below four. Each result is sampled one time unit after the inputs change, and a result that crosses a write is sampled once before and once after the capturing edge.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam int WORD_W   = 32;
    localparam int HI_LSB   = 28;   // exact-compare region [31:28]
    localparam int BLK_LSB  = 17;   // maskable region [27:17]
    localparam int BLK_W    = HI_LSB - BLK_LSB;
    localparam int LEN_LSB  = 2;    // length mask in tag [12:2]
    localparam int PASS_LSB = 12;   // pass-through region [16:12]
    localparam int PASS_W   = BLK_LSB - PASS_LSB;
    localparam int SV_BIT   = 1;
    localparam int UV_BIT   = 0;

    typedef enum logic [1:0] {
        XL_MISS  = 2'b00,
        XL_GRANT = 2'b01,
        XL_DENY  = 2'b10
    } xl_status_e;

    typedef enum logic [1:0] {
        RIGHTS_NONE = 2'b00,
        RIGHTS_RO_A = 2'b01,
        RIGHTS_RW   = 2'b10,
        RIGHTS_RO_B = 2'b11
    } rights_e;

    typedef struct packed {
        logic              match;
        logic              allow;
        logic [1:0]        prot;
        logic [WORD_W-1:0] paddr;
    } xl_hit_t;

endpackage

// File: rtl/bat_map_store.sv
module bat_map_store
    import bat_pkg::*;
#(
    parameter int N_ENTRIES = 4,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic                              cfg_instr,
    input  logic [IDX_W-1:0]                  cfg_idx,
    input  logic                              cfg_lower,
    input  logic [WORD_W-1:0]                 cfg_wdata,
    input  logic                              side_fetch,
    output logic [N_ENTRIES-1:0][WORD_W-1:0]  sel_tag,
    output logic [N_ENTRIES-1:0][WORD_W-1:0]  sel_tgt
);

    logic [N_ENTRIES-1:0][WORD_W-1:0] ins_tag, ins_tgt, dat_tag, dat_tgt;

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
        logic hit_idx;
        assign hit_idx = cfg_we && (cfg_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ins_tag[e] <= '0;
                ins_tgt[e] <= '0;
                dat_tag[e] <= '0;
                dat_tgt[e] <= '0;
            end else if (hit_idx) begin
                unique case ({cfg_instr, cfg_lower})
                    2'b10:   ins_tag[e] <= cfg_wdata;
                    2'b11:   ins_tgt[e] <= cfg_wdata;
                    2'b00:   dat_tag[e] <= cfg_wdata;
                    default: dat_tgt[e] <= cfg_wdata;
                endcase
            end
        end
    end

    always_comb begin
        if (side_fetch) begin
            sel_tag = ins_tag;
            sel_tgt = ins_tgt;
        end else begin
            sel_tag = dat_tag;
            sel_tgt = dat_tgt;
        end
    end

    // R8
    ins_tag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_instr && !cfg_lower)
        |=> ins_tag[$past(cfg_idx)] == $past(cfg_wdata));

    // R8
    dat_tgt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_instr && cfg_lower)
        |=> dat_tgt[$past(cfg_idx)] == $past(cfg_wdata));

    // R8
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(dat_tag) && $stable(ins_tgt));

endmodule

// File: rtl/bat_entry_match.sv
module bat_entry_match
    import bat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tag_w,
    input  logic [WORD_W-1:0] tgt_w,
    input  logic [WORD_W-1:0] ea,
    input  logic              is_user,
    input  logic              need_write,
    output xl_hit_t           hit
);

    logic [BLK_W-1:0] len_mask;
    logic             enabled, hi_eq, blk_eq;
    logic             rd_ok, wr_ok;
    rights_e          rights;

    assign len_mask = tag_w[LEN_LSB +: BLK_W];
    assign enabled  = is_user ? tag_w[UV_BIT] : tag_w[SV_BIT];
    assign hi_eq    = (ea[WORD_W-1:HI_LSB] == tag_w[WORD_W-1:HI_LSB]);
    assign blk_eq   = (((ea[HI_LSB-1:BLK_LSB] ^ tag_w[HI_LSB-1:BLK_LSB])
                        & ~len_mask) == '0);
    assign rights   = rights_e'(tgt_w[1:0]);

    always_comb begin
        unique case (rights)
            RIGHTS_NONE: begin rd_ok = 1'b0; wr_ok = 1'b0; end
            RIGHTS_RW:   begin rd_ok = 1'b1; wr_ok = 1'b1; end
            default:     begin rd_ok = 1'b1; wr_ok = 1'b0; end
        endcase
    end

    always_comb begin
        hit.match = enabled && hi_eq && blk_eq;
        hit.prot  = {wr_ok, rd_ok};
        hit.allow = need_write ? wr_ok : rd_ok;
        hit.paddr = {tgt_w[WORD_W-1:HI_LSB],
                     (ea[HI_LSB-1:BLK_LSB] & len_mask) | tgt_w[HI_LSB-1:BLK_LSB],
                     ea[BLK_LSB-1:PASS_LSB],
                     {PASS_LSB{1'b0}}};
    end

    logic unused_bits;
    assign unused_bits = ^{tag_w[BLK_LSB-1:LEN_LSB+BLK_W], tgt_w[BLK_LSB-1:2],
                           ea[PASS_LSB-1:0]};

    // R4
    hi_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit.match |-> ea[WORD_W-1:HI_LSB] == tag_w[WORD_W-1:HI_LSB]);

    // R3
    priv_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit.match |-> (is_user ? tag_w[UV_BIT] : tag_w[SV_BIT]));

endmodule

// File: rtl/bat_first_hit.sv
module bat_first_hit
    import bat_pkg::*;
#(
    parameter int N_ENTRIES = 4,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     active,
    input  xl_hit_t [N_ENTRIES-1:0]  hits,
    output xl_status_e               status,
    output logic [WORD_W-1:0]        paddr,
    output logic [1:0]               prot,
    output logic [IDX_W-1:0]         idx
);

    logic found;
    logic [N_ENTRIES-1:0] match_vec;

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_vec
        assign match_vec[e] = hits[e].match;
    end

    always_comb begin
        found  = 1'b0;
        status = XL_MISS;
        paddr  = '0;
        prot   = '0;
        idx    = '0;
        if (active) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (!found && hits[i].match) begin
                    found  = 1'b1;
                    idx    = IDX_W'(i);
                    paddr  = hits[i].paddr;
                    prot   = hits[i].prot;
                    status = hits[i].allow ? XL_GRANT : XL_DENY;
                end
            end
        end
    end

    // R6
    pick_is_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status != XL_MISS) |-> match_vec[idx]);

    // R6
    any_match_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (|match_vec)) |-> (status != XL_MISS));

    // R6
    entry0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && match_vec[0]) |-> (idx == '0));

endmodule

// File: rtl/bat_xlate_matcher.sv
module bat_xlate_matcher
    import bat_pkg::*;
#(
    parameter int N_ENTRIES = 4,
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_instr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_lower,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              req_fetch,
    input  logic              req_store,
    input  logic              req_user,
    output logic [1:0]        rsp_status,
    output logic [31:0]       rsp_paddr,
    output logic [1:0]        rsp_prot,
    output logic [IDX_W-1:0]  rsp_entry
);

    logic [N_ENTRIES-1:0][WORD_W-1:0] tag_arr, tgt_arr;
    xl_hit_t [N_ENTRIES-1:0]          hits;
    xl_status_e                       status;
    logic                             need_write;

    assign need_write = req_store && !req_fetch;

    bat_map_store #(.N_ENTRIES(N_ENTRIES)) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_instr  (cfg_instr),
        .cfg_idx    (cfg_idx),
        .cfg_lower  (cfg_lower),
        .cfg_wdata  (cfg_wdata),
        .side_fetch (req_fetch),
        .sel_tag    (tag_arr),
        .sel_tgt    (tgt_arr)
    );

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
        bat_entry_match cmp_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .tag_w      (tag_arr[e]),
            .tgt_w      (tgt_arr[e]),
            .ea         (req_addr),
            .is_user    (req_user),
            .need_write (need_write),
            .hit        (hits[e])
        );
    end

    bat_first_hit #(.N_ENTRIES(N_ENTRIES)) pick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (req_valid),
        .hits   (hits),
        .status (status),
        .paddr  (rsp_paddr),
        .prot   (rsp_prot),
        .idx    (rsp_entry)
    );

    assign rsp_status = status;

    // R9
    idle_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> rsp_status == XL_MISS);

    // R1
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_status == XL_MISS) |-> (rsp_paddr == '0 && rsp_prot == '0 && rsp_entry == '0));

    // R7
    status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_status != 2'b11);

    // R7
    store_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_status == XL_GRANT && req_store && !req_fetch) |-> rsp_prot[1]);

    // R7
    read_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_status == XL_DENY && !(req_store && !req_fetch)) |-> rsp_prot == 2'b00);

    // R5
    pass_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_status != XL_MISS) |-> (rsp_paddr[16:12] == req_addr[16:12]
                                     && rsp_paddr[11:0] == '0));

endmodule

// File: tb/bat_xlate_matcher_tb.sv
module bat_xlate_matcher_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_instr = 1'b0, cfg_lower = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_fetch = 1'b0, req_store = 1'b0, req_user = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  rsp_status, rsp_prot, rsp_entry;
    logic [31:0] rsp_paddr;

    int vec_cnt = 0;
    int bad_cnt = 0;

    localparam logic [1:0] S_MISS = 2'b00, S_OK = 2'b01, S_DENY = 2'b10;

    always #5 clk = ~clk;

    bat_xlate_matcher #(.N_ENTRIES(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_instr(cfg_instr), .cfg_idx(cfg_idx),
        .cfg_lower(cfg_lower), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_fetch(req_fetch),
        .req_store(req_store), .req_user(req_user),
        .rsp_status(rsp_status), .rsp_paddr(rsp_paddr),
        .rsp_prot(rsp_prot), .rsp_entry(rsp_entry)
    );

    task automatic check(input string tag, input logic [1:0] es,
                         input logic [31:0] ep, input logic [1:0] epr,
                         input logic [1:0] ee);
        vec_cnt++;
        if (rsp_status !== es || rsp_paddr !== ep || rsp_prot !== epr || rsp_entry !== ee) begin
            bad_cnt++;
            $display("FAIL %s: got status=%b paddr=%h prot=%b entry=%0d, expected status=%b paddr=%h prot=%b entry=%0d",
                     tag, rsp_status, rsp_paddr, rsp_prot, rsp_entry, es, ep, epr, ee);
        end
    endtask

    task automatic put_word(input logic instr, input logic [1:0] idx,
                            input logic lower, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_instr = instr; cfg_idx = idx; cfg_lower = lower; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ask(input logic [31:0] a, input logic f, input logic s, input logic u);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_fetch = f; req_store = s; req_user = u;
        #1;
    endtask

    task automatic t_reset;
        ask(32'h1000_0000, 1'b0, 1'b0, 1'b0);
        check("R1 data after reset", S_MISS, 32'h0, 2'b00, 2'd0);
        ask(32'h0000_0000, 1'b1, 1'b0, 1'b1);
        check("R1 fetch after reset", S_MISS, 32'h0, 2'b00, 2'd0);
    endtask

    task automatic t_basic;
        put_word(1'b0, 2'd0, 1'b0, 32'h1000_0002);
        put_word(1'b0, 2'd0, 1'b1, 32'h8000_0002);
        ask(32'h1000_5ABC, 1'b0, 1'b0, 1'b0);
        check("R5 basic compose", S_OK, 32'h8000_5000, 2'b11, 2'd0);
        ask(32'h1001_F123, 1'b0, 1'b1, 1'b0);
        check("R5 bit16 pass-through store", S_OK, 32'h8001_F000, 2'b11, 2'd0);
        ask(32'h1002_0000, 1'b0, 1'b0, 1'b0);
        check("R4 bit17 differs", S_MISS, 32'h0, 2'b00, 2'd0);
    endtask

    task automatic t_length;
        put_word(1'b0, 2'd1, 1'b0, 32'h2000_000E);
        put_word(1'b0, 2'd1, 1'b1, 32'h4000_0002);
        ask(32'h2006_3000, 1'b0, 1'b0, 1'b0);
        check("R4 R5 masked bits pass", S_OK, 32'h4006_3000, 2'b11, 2'd1);
        ask(32'h2008_0000, 1'b0, 1'b0, 1'b0);
        check("R4 unmasked bit19", S_MISS, 32'h0, 2'b00, 2'd0);
        put_word(1'b0, 2'd2, 1'b0, 32'h3000_1FFE);
        put_word(1'b0, 2'd2, 1'b1, 32'h5000_0002);
        ask(32'h3FFF_F000, 1'b0, 1'b0, 1'b0);
        check("R4 R5 full mask", S_OK, 32'h5FFF_F000, 2'b11, 2'd2);
        ask(32'h4000_0000, 1'b0, 1'b0, 1'b0);
        check("R4 top nibble exact", S_MISS, 32'h0, 2'b00, 2'd0);
    endtask

    task automatic t_priv;
        put_word(1'b0, 2'd3, 1'b0, 32'h6000_0001);
        put_word(1'b0, 2'd3, 1'b1, 32'h7000_0001);
        ask(32'h6000_1000, 1'b0, 1'b0, 1'b1);
        check("R3 user enable", S_OK, 32'h7000_1000, 2'b01, 2'd3);
        ask(32'h6000_1000, 1'b0, 1'b0, 1'b0);
        check("R3 supervisor disabled", S_MISS, 32'h0, 2'b00, 2'd0);
        ask(32'h1000_0000, 1'b0, 1'b0, 1'b1);
        check("R3 user on supervisor-only", S_MISS, 32'h0, 2'b00, 2'd0);
    endtask

    task automatic t_rights;
        ask(32'h6000_1000, 1'b0, 1'b1, 1'b1);
        check("R7 store on read-only", S_DENY, 32'h7000_1000, 2'b01, 2'd3);
        put_word(1'b0, 2'd3, 1'b1, 32'h7000_0000);
        ask(32'h6000_1000, 1'b0, 1'b0, 1'b1);
        check("R7 load on no-access", S_DENY, 32'h7000_1000, 2'b00, 2'd3);
        put_word(1'b0, 2'd3, 1'b1, 32'h7000_0003);
        ask(32'h6000_1000, 1'b0, 1'b1, 1'b1);
        check("R7 store on code 11", S_DENY, 32'h7000_1000, 2'b01, 2'd3);
        ask(32'h6000_1000, 1'b0, 1'b0, 1'b1);
        check("R7 load on code 11", S_OK, 32'h7000_1000, 2'b01, 2'd3);
    endtask

    task automatic t_priority;
        put_word(1'b0, 2'd1, 1'b0, 32'h1000_0002);
        put_word(1'b0, 2'd1, 1'b1, 32'h9000_0001);
        ask(32'h1000_0000, 1'b0, 1'b0, 1'b0);
        check("R6 lowest index wins", S_OK, 32'h8000_0000, 2'b11, 2'd0);
        put_word(1'b0, 2'd0, 1'b0, 32'h1000_0000);
        ask(32'h1000_0000, 1'b0, 1'b0, 1'b0);
        check("R6 next entry when first disabled", S_OK, 32'h9000_0000, 2'b01, 2'd1);
        put_word(1'b0, 2'd0, 1'b0, 32'h1000_0002);
        put_word(1'b0, 2'd0, 1'b1, 32'h8000_0000);
        put_word(1'b0, 2'd1, 1'b1, 32'h9000_0002);
        ask(32'h1000_0000, 1'b0, 1'b0, 1'b0);
        check("R6 first match denies, no fallthrough", S_DENY, 32'h8000_0000, 2'b00, 2'd0);
    endtask

    task automatic t_sides;
        ask(32'h1000_0000, 1'b1, 1'b0, 1'b0);
        check("R2 fetch ignores data array", S_MISS, 32'h0, 2'b00, 2'd0);
        put_word(1'b1, 2'd0, 1'b0, 32'hA000_0002);
        put_word(1'b1, 2'd0, 1'b1, 32'hB000_0001);
        ask(32'hA000_0000, 1'b1, 1'b0, 1'b0);
        check("R2 fetch hits instruction array", S_OK, 32'hB000_0000, 2'b01, 2'd0);
        ask(32'hA000_0000, 1'b1, 1'b1, 1'b0);
        check("R7 store flag ignored on fetch", S_OK, 32'hB000_0000, 2'b01, 2'd0);
        ask(32'hA000_0000, 1'b0, 1'b0, 1'b0);
        check("R2 load ignores instruction array", S_MISS, 32'h0, 2'b00, 2'd0);
    endtask

    task automatic t_write_timing;
        @(negedge clk);
        cfg_we = 1'b1; cfg_instr = 1'b0; cfg_idx = 2'd3; cfg_lower = 1'b0;
        cfg_wdata = 32'h6000_0003;
        req_valid = 1'b1; req_addr = 32'h6000_1000; req_fetch = 1'b0;
        req_store = 1'b0; req_user = 1'b0;
        #1;
        check("R8 old value before edge", S_MISS, 32'h0, 2'b00, 2'd0);
        @(posedge clk);
        #1;
        check("R8 new value after edge", S_OK, 32'h7000_1000, 2'b01, 2'd3);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_idle;
        ask(32'h6000_1000, 1'b0, 1'b0, 1'b0);
        check("R9 same-cycle result", S_OK, 32'h7000_1000, 2'b01, 2'd3);
        req_valid = 1'b0;
        #1;
        check("R9 no request", S_MISS, 32'h0, 2'b00, 2'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_length();
        t_priv();
        t_rights();
        t_priority();
        t_sides();
        t_write_timing();
        t_idle();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad_cnt++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    end

endmodule